// File: doc/BRIEF.md
# Memory reference command translator

This block sits between a core's memory pipeline and its external bus interface. Each cycle it may accept one internal memory reference over a valid/ready handshake. A reference carries an instruction class, an I/O-space flag, an access size, a flag that marks a zero destination register, a modify-intent flag and a physical address. The current primary-cache and secondary-cache hit and writable status comes with it. From these inputs the block picks a single external action. The action is one of: complete, enter the set-dirty flow, fail, do nothing, or issue a bus command. A bus command comes with its encoding and the address to send.

Loads that target the zero register are prefetches. They are steered into the load flow, or into the store flow when they carry modify intent, and they always go to memory space. A store-conditional also reports a one-bit success result alongside its action. The decision is registered in a single output stage with backpressure.

Top module: `mref_xlate`

## Requirements
- R1: `in_ready` is high exactly when the output stage is empty or `out_ready` is high. An accepted reference appears on the outputs one clock later. While `out_valid` is high and `out_ready` is low, every output holds its value.
- R2: A load (class 0) to memory that hits either cache yields action done (0). If it misses both caches, it yields action bus (4) with command read-block (4).
- R3: A load to I/O space yields action bus with a read command chosen by size, whatever the cache status. Sizes byte (0) and word (1) give read-bytes (1), size long (2) gives read-longwords (2), and size quad (3) gives read-quadwords (3).
- R4: An instruction fetch (class 1) that hits either cache yields done. If it misses both, it yields bus with command read-block-for-fetch (5). The I/O flag does not change this choice.
- R5: A store (class 2) to memory first checks the primary cache. A primary hit gives done if the line is writable and set-dirty (1) if not. Otherwise a secondary hit gives done if writable and set-dirty if not. A miss in both gives bus with read-block-modify (6).
- R6: A store to I/O space yields bus with a write command chosen by size: write-bytes (7) for byte or word, write-longwords (8) for long, write-quadwords (9) for quad.
- R7: A store-conditional (class 3) to memory fails (action 2) with `out_sc_ok` 0 on a primary miss, whatever the secondary status. A primary hit gives done if writable and set-dirty if not, both with `out_sc_ok` 1.
- R8: A store-conditional to I/O space yields bus with write-quadwords for size quad and write-longwords for any other size, with `out_sc_ok` 1.
- R9: Write-hint-64 (class 4) to memory follows the R5 hit rules. A miss in both caches gives bus with invalidate-to-dirty (10). To I/O space it gives NOP (3).
- R10: Evict-block (class 5) to memory gives bus with evict (11), and to I/O space gives NOP. A barrier (class 6) always gives bus with barrier (12). The unused class 7 gives NOP.
- R11: A load with the zero-destination flag is a prefetch. It uses the load flow, or the store flow when the modify-intent flag is also set, and it is handled as a memory reference even when the I/O flag is set. The modify-intent flag has no effect on other references.
- R12: When the reference is handled as a memory reference, `out_addr` has its low `BLK_BITS` bits cleared. A prefetch also has address bit `PA_W-1` cleared. An I/O-space reference that is not a prefetch passes its address unchanged.
- R13: `out_cmd` is 0 whenever the action is not bus, and `out_sc_ok` is 0 for every class except store-conditional.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Reference offered |
| in_ready | output | 1 | Reference will be taken this cycle |
| in_cls | input | 3 | Instruction class code |
| in_io | input | 1 | Address is in I/O space |
| in_size | input | 2 | Access size code |
| in_dst_zero | input | 1 | Destination is the zero register |
| in_mod_pf | input | 1 | Load form that means modify-intent prefetch |
| in_addr | input | PA_W | Physical address |
| st_l1_hit | input | 1 | Primary cache hit |
| st_l1_wr | input | 1 | Primary cache line writable |
| st_l2_hit | input | 1 | Secondary cache hit |
| st_l2_wr | input | 1 | Secondary cache line writable |
| out_valid | output | 1 | Result held in output stage |
| out_ready | input | 1 | Consumer takes the result |
| out_act | output | 3 | Action code |
| out_cmd | output | 4 | Bus command code |
| out_addr | output | PA_W | Address to send |
| out_sc_ok | output | 1 | Store-conditional success |

## Verification
The bench builds the block with its defaults, `PA_W` = 43 and `BLK_BITS` = 6. With these values the cleared top bit is bit 42 and the block offset is six bits wide. It drives addresses with bit 42 and all low bits set, so clearing either part is visible. The consumer stalls one cycle in four, which exercises the hold rule and back-to-back acceptance under backpressure alongside every class, space, size and status combination.

// File: rtl/mref_pkg.sv
package mref_pkg;

    typedef enum logic [2:0] {
        CLS_LOAD    = 3'd0,
        CLS_IFETCH  = 3'd1,
        CLS_STORE   = 3'd2,
        CLS_STCOND  = 3'd3,
        CLS_WH64    = 3'd4,
        CLS_EVICT   = 3'd5,
        CLS_BARRIER = 3'd6,
        CLS_RSVD    = 3'd7
    } ref_cls_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_QUAD = 2'd3
    } ref_size_e;

    typedef enum logic [2:0] {
        ACT_DONE      = 3'd0,
        ACT_SET_DIRTY = 3'd1,
        ACT_FAIL      = 3'd2,
        ACT_NOP       = 3'd3,
        ACT_BUS       = 3'd4
    } act_e;

    typedef enum logic [3:0] {
        CMD_NONE        = 4'd0,
        CMD_RD_BYTE     = 4'd1,
        CMD_RD_LONG     = 4'd2,
        CMD_RD_QUAD     = 4'd3,
        CMD_RD_BLK      = 4'd4,
        CMD_RD_BLK_I    = 4'd5,
        CMD_RD_BLK_MOD  = 4'd6,
        CMD_WR_BYTE     = 4'd7,
        CMD_WR_LONG     = 4'd8,
        CMD_WR_QUAD     = 4'd9,
        CMD_INVAL_DIRTY = 4'd10,
        CMD_EVICT       = 4'd11,
        CMD_BARRIER     = 4'd12
    } cmd_e;

    typedef enum logic [2:0] {
        FLOW_LOAD, FLOW_FETCH, FLOW_STORE, FLOW_STCOND,
        FLOW_WH64, FLOW_EVICT, FLOW_BARRIER, FLOW_NONE
    } flow_e;

    typedef struct packed {
        flow_e     flow;
        logic      io_eff;
        ref_size_e size;
    } ref_info_t;

    typedef struct packed {
        logic l1_hit;
        logic l1_wr;
        logic l2_hit;
        logic l2_wr;
    } cache_st_t;

    typedef struct packed {
        act_e act;
        cmd_e cmd;
        logic sc_ok;
    } result_t;

    function automatic result_t mk_res(act_e a, cmd_e c, logic ok);
        result_t r;
        r.act   = a;
        r.cmd   = c;
        r.sc_ok = ok;
        return r;
    endfunction

    function automatic cmd_e io_read_cmd(ref_size_e s);
        case (s)
            SZ_QUAD: return CMD_RD_QUAD;
            SZ_LONG: return CMD_RD_LONG;
            default: return CMD_RD_BYTE;
        endcase
    endfunction

    function automatic cmd_e io_write_cmd(ref_size_e s);
        case (s)
            SZ_QUAD: return CMD_WR_QUAD;
            SZ_LONG: return CMD_WR_LONG;
            default: return CMD_WR_BYTE;
        endcase
    endfunction

    // Write-intent hit ladder shared by stores and write-hint-64.
    function automatic result_t write_ladder(cache_st_t st, cmd_e miss_cmd);
        if (st.l1_hit)
            return mk_res(st.l1_wr ? ACT_DONE : ACT_SET_DIRTY, CMD_NONE, 1'b0);
        if (st.l2_hit)
            return mk_res(st.l2_wr ? ACT_DONE : ACT_SET_DIRTY, CMD_NONE, 1'b0);
        return mk_res(ACT_BUS, miss_cmd, 1'b0);
    endfunction

endpackage

// File: rtl/mref_decode.sv
module mref_decode
    import mref_pkg::*;
#(
    parameter int PA_W     = 43,
    parameter int BLK_BITS = 6
) (
    input  logic [2:0]      cls,
    input  logic            io,
    input  logic [1:0]      size,
    input  logic            dst_zero,
    input  logic            mod_pf,
    input  logic [PA_W-1:0] addr,
    output ref_info_t       info,
    output logic [PA_W-1:0] addr_out
);
    localparam int TOP = PA_W - 1;

    ref_cls_e c;
    logic     pf;

    always_comb begin
        c  = ref_cls_e'(cls);
        pf = (c == CLS_LOAD) && dst_zero;

        case (c)
            CLS_LOAD:    info.flow = (pf && mod_pf) ? FLOW_STORE : FLOW_LOAD;
            CLS_IFETCH:  info.flow = FLOW_FETCH;
            CLS_STORE:   info.flow = FLOW_STORE;
            CLS_STCOND:  info.flow = FLOW_STCOND;
            CLS_WH64:    info.flow = FLOW_WH64;
            CLS_EVICT:   info.flow = FLOW_EVICT;
            CLS_BARRIER: info.flow = FLOW_BARRIER;
            default:     info.flow = FLOW_NONE;
        endcase

        info.io_eff = io && !pf;
        info.size   = ref_size_e'(size);

        addr_out = addr;
        if (!info.io_eff) begin
            addr_out[BLK_BITS-1:0] = '0;
            if (pf) addr_out[TOP] = 1'b0;
        end
    end
endmodule

// File: rtl/mref_cmd_sel.sv
module mref_cmd_sel
    import mref_pkg::*;
(
    input  ref_info_t info,
    input  cache_st_t st,
    output result_t   res
);
    logic any_hit;

    always_comb begin
        any_hit = st.l1_hit || st.l2_hit;
        res     = mk_res(ACT_NOP, CMD_NONE, 1'b0);

        case (info.flow)
            FLOW_LOAD: begin
                if (info.io_eff)  res = mk_res(ACT_BUS, io_read_cmd(info.size), 1'b0);
                else if (any_hit) res = mk_res(ACT_DONE, CMD_NONE, 1'b0);
                else              res = mk_res(ACT_BUS, CMD_RD_BLK, 1'b0);
            end
            FLOW_FETCH: begin
                if (any_hit) res = mk_res(ACT_DONE, CMD_NONE, 1'b0);
                else         res = mk_res(ACT_BUS, CMD_RD_BLK_I, 1'b0);
            end
            FLOW_STORE: begin
                if (info.io_eff) res = mk_res(ACT_BUS, io_write_cmd(info.size), 1'b0);
                else             res = write_ladder(st, CMD_RD_BLK_MOD);
            end
            FLOW_STCOND: begin
                if (info.io_eff)
                    res = mk_res(ACT_BUS,
                                 (info.size == SZ_QUAD) ? CMD_WR_QUAD : CMD_WR_LONG, 1'b1);
                else if (!st.l1_hit)
                    res = mk_res(ACT_FAIL, CMD_NONE, 1'b0);
                else
                    res = mk_res(st.l1_wr ? ACT_DONE : ACT_SET_DIRTY, CMD_NONE, 1'b1);
            end
            FLOW_WH64: begin
                if (info.io_eff) res = mk_res(ACT_NOP, CMD_NONE, 1'b0);
                else             res = write_ladder(st, CMD_INVAL_DIRTY);
            end
            FLOW_EVICT: begin
                if (info.io_eff) res = mk_res(ACT_NOP, CMD_NONE, 1'b0);
                else             res = mk_res(ACT_BUS, CMD_EVICT, 1'b0);
            end
            FLOW_BARRIER: res = mk_res(ACT_BUS, CMD_BARRIER, 1'b0);
            default:      res = mk_res(ACT_NOP, CMD_NONE, 1'b0);
        endcase
    end
endmodule

// File: rtl/mref_out_reg.sv
module mref_out_reg
    import mref_pkg::*;
#(
    parameter int PA_W = 43
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  result_t         d_res,
    input  logic [PA_W-1:0] d_addr,
    output logic            out_valid,
    input  logic            out_ready,
    output result_t         q_res,
    output logic [PA_W-1:0] q_addr
);
    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            q_res     <= mk_res(ACT_NOP, CMD_NONE, 1'b0);
            q_addr    <= '0;
        end else if (in_valid && in_ready) begin
            out_valid <= 1'b1;
            q_res     <= d_res;
            q_addr    <= d_addr;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R1: a stalled result stays put
    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(q_res) && $stable(q_addr)));
endmodule

// File: rtl/mref_xlate.sv
module mref_xlate
    import mref_pkg::*;
#(
    parameter int PA_W     = 43,
    parameter int BLK_BITS = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [2:0]      in_cls,
    input  logic            in_io,
    input  logic [1:0]      in_size,
    input  logic            in_dst_zero,
    input  logic            in_mod_pf,
    input  logic [PA_W-1:0] in_addr,
    input  logic            st_l1_hit,
    input  logic            st_l1_wr,
    input  logic            st_l2_hit,
    input  logic            st_l2_wr,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [2:0]      out_act,
    output logic [3:0]      out_cmd,
    output logic [PA_W-1:0] out_addr,
    output logic            out_sc_ok
);
    ref_info_t       info;
    logic [PA_W-1:0] d_addr;
    result_t         d_res;
    result_t         q_res;
    cache_st_t       st;

    assign st = '{l1_hit: st_l1_hit, l1_wr: st_l1_wr, l2_hit: st_l2_hit, l2_wr: st_l2_wr};

    mref_decode #(.PA_W(PA_W), .BLK_BITS(BLK_BITS)) u_dec (
        .cls(in_cls), .io(in_io), .size(in_size), .dst_zero(in_dst_zero),
        .mod_pf(in_mod_pf), .addr(in_addr), .info(info), .addr_out(d_addr)
    );

    mref_cmd_sel u_sel (.info(info), .st(st), .res(d_res));

    mref_out_reg #(.PA_W(PA_W)) u_oreg (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .d_res(d_res), .d_addr(d_addr), .out_valid(out_valid),
        .out_ready(out_ready), .q_res(q_res), .q_addr(out_addr)
    );

    assign out_act   = q_res.act;
    assign out_cmd   = q_res.cmd;
    assign out_sc_ok = q_res.sc_ok;

    p_cmd_idle_r13: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_act != 3'd4) |-> (out_cmd == 4'd0));

    p_fail_sc_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_act == 3'd2) |-> !out_sc_ok);

    p_barrier_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_cls == 3'd6) |=> (out_valid && out_cmd == 4'd12));

    p_pf_mem_r11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_cls == 3'd0 && in_dst_zero) |=> !out_addr[PA_W-1]);

    p_align_r12: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !in_io) |=> (out_addr[BLK_BITS-1:0] == '0));
endmodule

// File: tb/mref_xlate_tb.sv
module mref_xlate_tb_top;
    localparam int PA_W = 43;

    typedef struct packed {
        logic [2:0]      act;
        logic [3:0]      cmd;
        logic [PA_W-1:0] addr;
        logic            ok;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [2:0]      in_cls = '0;
    logic            in_io = 1'b0;
    logic [1:0]      in_size = '0;
    logic            in_dst_zero = 1'b0;
    logic            in_mod_pf = 1'b0;
    logic [PA_W-1:0] in_addr = '0;
    logic            st_l1_hit = 1'b0, st_l1_wr = 1'b0, st_l2_hit = 1'b0, st_l2_wr = 1'b0;
    logic            out_valid;
    logic            out_ready = 1'b1;
    logic [2:0]      out_act;
    logic [3:0]      out_cmd;
    logic [PA_W-1:0] out_addr;
    logic            out_sc_ok;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cyc      = 0;
    exp_t  exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    mref_xlate dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_cls(in_cls), .in_io(in_io), .in_size(in_size), .in_dst_zero(in_dst_zero),
        .in_mod_pf(in_mod_pf), .in_addr(in_addr), .st_l1_hit(st_l1_hit),
        .st_l1_wr(st_l1_wr), .st_l2_hit(st_l2_hit), .st_l2_wr(st_l2_wr),
        .out_valid(out_valid), .out_ready(out_ready), .out_act(out_act),
        .out_cmd(out_cmd), .out_addr(out_addr), .out_sc_ok(out_sc_ok)
    );

    localparam logic [PA_W-1:0] A_HI  = 43'h4AB_CDEF_013F;
    localparam logic [PA_W-1:0] A_MEM = 43'h012_3456_78BF;

    function automatic exp_t model(input logic [2:0] c, input logic io, input logic [1:0] sz,
                                   input logic dz, input logic mf, input logic [PA_W-1:0] a,
                                   input logic h1, input logic w1, input logic h2, input logic w2);
        exp_t e;
        logic pf, iom;
        logic [2:0] k;
        logic [3:0] miss;
        pf  = (c == 3'd0) && dz;
        iom = io && !pf;
        k   = (pf && mf) ? 3'd2 : c;
        e.addr = a;
        if (!iom) begin
            e.addr[5:0] = '0;
            if (pf) e.addr[42] = 1'b0;
        end
        e.act = 3'd0; e.cmd = 4'd0; e.ok = 1'b0;
        miss = (k == 3'd4) ? 4'd10 : 4'd6;
        case (k)
            3'd0: if (iom) begin e.act = 4; e.cmd = (sz == 3) ? 4'd3 : (sz == 2) ? 4'd2 : 4'd1; end
                  else if (!(h1 || h2)) begin e.act = 4; e.cmd = 4; end
            3'd1: if (!(h1 || h2)) begin e.act = 4; e.cmd = 5; end
            3'd2, 3'd4: begin
                if (iom && k == 3'd4) e.act = 3;
                else if (iom) begin e.act = 4; e.cmd = (sz == 3) ? 4'd9 : (sz == 2) ? 4'd8 : 4'd7; end
                else if (h1) e.act = w1 ? 3'd0 : 3'd1;
                else if (h2) e.act = w2 ? 3'd0 : 3'd1;
                else begin e.act = 4; e.cmd = miss; end
            end
            3'd3: if (iom) begin e.act = 4; e.cmd = (sz == 3) ? 4'd9 : 4'd8; e.ok = 1; end
                  else if (!h1) e.act = 2;
                  else begin e.act = w1 ? 3'd0 : 3'd1; e.ok = 1; end
            3'd5: if (iom) e.act = 3; else begin e.act = 4; e.cmd = 11; end
            3'd6: begin e.act = 4; e.cmd = 12; end
            default: e.act = 3;
        endcase
        return e;
    endfunction

    task automatic send(input logic [2:0] c, input logic io, input logic [1:0] sz,
                        input logic dz, input logic mf, input logic [PA_W-1:0] a,
                        input logic h1, input logic w1, input logic h2, input logic w2,
                        input string tag);
        @(posedge clk); #1;
        in_cls = c; in_io = io; in_size = sz; in_dst_zero = dz; in_mod_pf = mf;
        in_addr = a; st_l1_hit = h1; st_l1_wr = w1; st_l2_hit = h2; st_l2_wr = w2;
        in_valid = 1'b1;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        exp_q.push_back(model(c, io, sz, dz, mf, a, h1, w1, h2, w2));
        tag_q.push_back(tag);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // Consumer backpressure: stall one cycle in four.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #2 out_ready = (cyc % 4 != 2);
    end

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            exp_t  e;
            string t;
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R1: unexpected result act=%0d cmd=%0d expected none", out_act, out_cmd);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (out_act !== e.act || out_cmd !== e.cmd || out_addr !== e.addr || out_sc_ok !== e.ok) begin
                    n_fail++;
                    $display("FAIL %s: act=%0d cmd=%0d addr=%h ok=%0d expected act=%0d cmd=%0d addr=%h ok=%0d",
                             t, out_act, out_cmd, out_addr, out_sc_ok, e.act, e.cmd, e.addr, e.ok);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R1: watchdog expired, actual hung expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            n_fail++;
            $display("FAIL R1: reset out_valid=%0d in_ready=%0d expected 0 1", out_valid, in_ready);
        end

        // R2 load to memory
        send(0, 0, 3, 0, 0, A_MEM, 1, 0, 0, 0, "R2");
        send(0, 0, 3, 0, 0, A_MEM, 0, 0, 1, 0, "R2");
        send(0, 0, 3, 0, 0, A_HI,  0, 0, 0, 0, "R2");
        // R3 load to I/O, every size, status ignored
        for (int s = 0; s < 4; s++) send(0, 1, 2'(s), 0, 0, A_HI, 1, 1, 1, 1, "R3");
        // R4 instruction fetch
        send(1, 0, 0, 0, 0, A_MEM, 1, 0, 0, 0, "R4");
        send(1, 0, 0, 0, 0, A_MEM, 0, 0, 1, 1, "R4");
        send(1, 0, 0, 0, 0, A_MEM, 0, 0, 0, 0, "R4");
        send(1, 1, 0, 0, 0, A_HI,  0, 0, 0, 0, "R4");
        // R5 store ladder, all 16 status combinations
        for (int m = 0; m < 16; m++)
            send(2, 0, 3, 0, 0, A_MEM, m[3], m[2], m[1], m[0], "R5");
        // R6 store to I/O
        for (int s = 0; s < 4; s++) send(2, 1, 2'(s), 0, 0, A_HI, 0, 0, 0, 0, "R6");
        // R7 store-conditional to memory
        for (int m = 0; m < 16; m++)
            send(3, 0, 3, 0, 0, A_MEM, m[3], m[2], m[1], m[0], "R7");
        // R8 store-conditional to I/O
        for (int s = 0; s < 4; s++) send(3, 1, 2'(s), 0, 0, A_HI, 0, 0, 0, 0, "R8");
        // R9 write-hint-64
        for (int m = 0; m < 16; m++)
            send(4, 0, 3, 0, 0, A_MEM, m[3], m[2], m[1], m[0], "R9");
        send(4, 1, 3, 0, 0, A_HI, 0, 0, 0, 0, "R9");
        // R10 evict, barrier, reserved class
        send(5, 0, 3, 0, 0, A_MEM, 1, 1, 1, 1, "R10");
        send(5, 1, 3, 0, 0, A_HI,  0, 0, 0, 0, "R10");
        send(6, 0, 0, 0, 0, A_MEM, 0, 0, 0, 0, "R10");
        send(6, 1, 0, 0, 0, A_HI,  1, 1, 1, 1, "R10");
        send(7, 0, 0, 0, 0, A_MEM, 0, 0, 0, 0, "R10");
        // R11 prefetches, incl. to I/O and with modify intent
        send(0, 1, 2, 1, 0, A_HI, 0, 0, 0, 0, "R11");
        send(0, 1, 2, 1, 1, A_HI, 0, 0, 0, 0, "R11");
        send(0, 1, 2, 1, 1, A_HI, 1, 0, 0, 0, "R11");
        send(0, 0, 2, 1, 0, A_MEM, 0, 0, 1, 0, "R11");
        send(0, 0, 2, 0, 1, A_MEM, 0, 0, 0, 0, "R11");
        send(2, 0, 2, 1, 1, A_MEM, 0, 0, 0, 0, "R11");
        // R12 address handling: I/O passes unchanged, memory aligned
        send(2, 1, 1, 0, 0, A_HI, 0, 0, 0, 0, "R12");
        send(5, 0, 0, 0, 0, A_HI, 0, 0, 0, 0, "R12");
        // R13 non-bus actions carry no command, sc_ok low elsewhere
        send(2, 0, 3, 0, 0, A_MEM, 1, 1, 0, 0, "R13");
        send(4, 1, 3, 0, 0, A_MEM, 0, 0, 0, 0, "R13");

        begin
            int guard = 0;
            while (exp_q.size() != 0 && guard < 100) begin
                @(posedge clk); guard++;
            end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0 || out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: pending=%0d out_valid=%0d expected 0 0", exp_q.size(), out_valid);
        end
        finish_run();
    end
endmodule